// File: doc/BRIEF.md
# Serial Receive DMA Channel

This channel drains 16-bit words from a serial receiver into memory. Software hands it one descriptor at a time. A descriptor gives a start address, a word count, an address for the status record, a transfer size and two interrupt enables. Incoming words land in a small internal FIFO. While a block is active, the channel writes each FIFO word to memory at the chosen width and advances the address after every write. When the count runs out, it writes one 32-bit result record to the status address. That record states whether a receive overflow happened during the block.

With the DMA enable low, the channel makes no memory transfers. Each received word instead produces a one-cycle word interrupt. The core then takes the word from the FIFO head through a simple read strobe.

Overflow is flagged when a word arrives while the FIFO is full. That word is lost. The overflow flag stays set until the next descriptor is taken. The record bit is cleared once the record has been written. Two status bits (block done, overflow error) drive a single interrupt line and are cleared by writing 1.

Top module: `srx_dma_chan`

## Requirements
- R1: While `dma_en` is low, no memory write is issued. Every word accepted into the FIFO raises `word_irq` for exactly one cycle, starting the cycle after arrival. `pio_data` shows the FIFO head, and `pio_rd` removes it.
- R2: A descriptor is taken when `desc_valid` and `dma_en` are high and the channel is idle. `busy` is high from the next cycle until the status record has been written.
- R3: A word arriving (`ser_valid`) while the FIFO already holds `FIFO_DEPTH` words is dropped. `ovf_flag` is high from the next cycle and stays high, even past the end of the block, until the next descriptor is taken.
- R4: The `desc_size` and `mem_size` encoding is 00 for 8-bit, 01 for 16-bit and 10 for 32-bit. For 8-bit, `mem_wdata` is `{24'h0, word[7:0]}`. For 16-bit and 32-bit, it is `{16'h0, word}`. Code 11 behaves as 16-bit and appears as 01 on `mem_size`.
- R5: Data writes go to `desc_addr`, then step by 1, 2 or 4 bytes per write for 8, 16 or 32-bit size. Words are written in arrival order.
- R6: After `desc_count` data writes, one write with `mem_size` 10 goes to `desc_stat_addr`. Its `mem_wdata` is 1 if an overflow happened since the descriptor was taken, and 0 otherwise. The next block starts its record from 0.
- R7: If `desc_done_ie` was set, `irq_stat[0]` is set when the status record write completes. Otherwise it stays clear.
- R8: If `desc_err_ie` was set, an overflow sets `irq_stat[1]`. Otherwise it stays clear.
- R9: A 1 on `irq_clr[i]` clears `irq_stat[i]` on the next edge; a same-cycle set wins. `irq` is high exactly when some `irq_stat` bit is set.
- R10: While `mem_ready` is low, a pending `mem_wr` stays asserted at the same `mem_addr`, and nothing advances.
- R11: After reset, `busy`, `mem_wr`, `irq`, `irq_stat`, `ovf_flag` and `word_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | 1: descriptor mode, 0: word-interrupt mode |
| desc_valid | input | 1 | Descriptor offered |
| desc_addr | input | ADDR_W | First data address |
| desc_stat_addr | input | ADDR_W | Status record address |
| desc_count | input | CNT_W | Data words in the block |
| desc_size | input | 2 | Transfer size code |
| desc_done_ie | input | 1 | Interrupt on block completion |
| desc_err_ie | input | 1 | Interrupt on overflow |
| busy | output | 1 | Block in progress |
| ser_valid | input | 1 | Word from serial receiver |
| ser_data | input | 16 | Received word |
| pio_rd | input | 1 | Core pops FIFO head (DMA off) |
| pio_data | output | 16 | FIFO head |
| word_irq | output | 1 | Per-word interrupt pulse (DMA off) |
| mem_wr | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts write this cycle |
| mem_addr | output | ADDR_W | Write byte address |
| mem_size | output | 2 | Write size code |
| mem_wdata | output | 32 | Write data |
| irq_clr | input | 2 | Write-1-to-clear for status bits |
| irq_stat | output | 2 | bit0 block done, bit1 overflow error |
| irq | output | 1 | Channel interrupt |
| ovf_flag | output | 1 | Overflow seen in current block |

## Verification
The properties rely on two assumptions about the inputs. First, `dma_en` changes only while `busy` is low. Second, the memory side never drops a request it has not granted. The first assumption is what lets "no write without DMA" be checked as a plain implication. The bench toggles `dma_en` only between blocks, after waiting for `busy` to fall. It holds `mem_ready` low only as a steady stall, never as a pulse pattern that depends on `mem_wr`.

// File: rtl/srx_dma_pkg.sv
package srx_dma_pkg;

    localparam int FIFO_W = 16;
    localparam int MEM_W  = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_STAT
    } chan_state_e;

    typedef struct packed {
        logic       done_ie;
        logic       err_ie;
        xfer_size_e size;
    } chan_cfg_t;

    // reserved code 11 falls back to 16-bit
    function automatic xfer_size_e norm_size(input logic [1:0] raw);
        case (raw)
            2'b00:   return SZ_BYTE;
            2'b10:   return SZ_WORD;
            default: return SZ_HALF;
        endcase
    endfunction

    function automatic logic [2:0] size_step(input xfer_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign dout    = store[rp];

    always_ff @(posedge clk) begin
        if (do_push) store[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            fill <= fill + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/srx_pack.sv
module srx_pack
    import srx_dma_pkg::*;
(
    input  xfer_size_e        size,
    input  logic [FIFO_W-1:0] word,
    output logic [MEM_W-1:0]  wdata
);
    always_comb begin
        wdata = '0;
        wdata[FIFO_W-1:0] = word;
        if (size == SZ_BYTE) wdata[MEM_W-1:8] = '0;
    end
endmodule

// File: rtl/srx_irq.sv
module srx_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_done,
    input  logic       set_err,
    input  logic [1:0] clr,
    output logic [1:0] stat,
    output logic       irq
);
    logic [1:0] setv;
    assign setv = {set_err, set_done};

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr) | setv;
    end

    assign irq = |stat;
endmodule

// File: rtl/srx_dma_chan.sv
module srx_dma_chan
    import srx_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              desc_valid,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [ADDR_W-1:0] desc_stat_addr,
    input  logic [CNT_W-1:0]  desc_count,
    input  logic [1:0]        desc_size,
    input  logic              desc_done_ie,
    input  logic              desc_err_ie,
    output logic              busy,
    input  logic              ser_valid,
    input  logic [15:0]       ser_data,
    input  logic              pio_rd,
    output logic [15:0]       pio_data,
    output logic              word_irq,
    output logic              mem_wr,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [1:0]        irq_clr,
    output logic [1:0]        irq_stat,
    output logic              irq,
    output logic              ovf_flag
);
    chan_state_e       state;
    chan_cfg_t         cfg;
    logic [ADDR_W-1:0] cur_addr, rec_addr;
    logic [CNT_W-1:0]  remain;
    logic              comp_bit;

    logic              fifo_full, fifo_empty, fifo_pop, fifo_push;
    logic [FIFO_W-1:0] fifo_head;
    logic [MEM_W-1:0]  data_word;
    logic              ovf_evt, desc_fire, data_go, stat_go;

    assign ovf_evt   = ser_valid && fifo_full;
    assign fifo_push = ser_valid && !fifo_full;
    assign desc_fire = desc_valid && dma_en && (state == ST_IDLE);
    assign data_go   = (state == ST_DATA) && !fifo_empty && mem_ready;
    assign stat_go   = (state == ST_STAT) && mem_ready;
    assign fifo_pop  = data_go || (pio_rd && !dma_en);

    srx_fifo #(.W(FIFO_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   (ser_data),
        .dout  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    srx_pack u_pack (
        .size  (cfg.size),
        .word  (fifo_head),
        .wdata (data_word)
    );

    srx_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_done (stat_go && cfg.done_ie),
        .set_err  (ovf_evt && cfg.err_ie),
        .clr      (irq_clr),
        .stat     (irq_stat),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg      <= '{done_ie: 1'b0, err_ie: 1'b0, size: SZ_HALF};
            cur_addr <= '0;
            rec_addr <= '0;
            remain   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (desc_fire) begin
                    cur_addr <= desc_addr;
                    rec_addr <= desc_stat_addr;
                    remain   <= desc_count;
                    cfg      <= '{done_ie: desc_done_ie, err_ie: desc_err_ie,
                                  size: norm_size(desc_size)};
                    state    <= (desc_count == '0) ? ST_STAT : ST_DATA;
                end
                ST_DATA: if (data_go) begin
                    cur_addr <= cur_addr + ADDR_W'(size_step(cfg.size));
                    remain   <= remain - 1'b1;
                    if (remain == CNT_W'(1)) state <= ST_STAT;
                end
                ST_STAT: if (stat_go) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // overflow bookkeeping: a new overflow wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            comp_bit <= 1'b0;
            word_irq <= 1'b0;
        end else begin
            if (ovf_evt)        ovf_flag <= 1'b1;
            else if (desc_fire) ovf_flag <= 1'b0;
            if (ovf_evt)                   comp_bit <= 1'b1;
            else if (desc_fire || stat_go) comp_bit <= 1'b0;
            word_irq <= fifo_push && !dma_en;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign pio_data  = fifo_head;
    assign mem_wr    = ((state == ST_DATA) && !fifo_empty) || (state == ST_STAT);
    assign mem_addr  = (state == ST_STAT) ? rec_addr : cur_addr;
    assign mem_size  = (state == ST_STAT) ? SZ_WORD : cfg.size;
    assign mem_wdata = (state == ST_STAT) ? {{(MEM_W-1){1'b0}}, comp_bit} : data_word;
endmodule

// File: rtl/srx_dma_chk.sv
module srx_dma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              dma_en,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic [31:0]       mem_wdata,
    input logic              busy,
    input logic              ovf_flag,
    input logic              desc_fire,
    input logic              ovf_evt,
    input logic [1:0]        irq_stat
);
    p_no_wr_r1: assert property (@(posedge clk) disable iff (rst)
        !dma_en |-> !mem_wr);

    p_busy_r2: assert property (@(posedge clk) disable iff (rst)
        desc_fire |=> busy);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !desc_fire) |=> ovf_flag);

    p_size_legal_r4: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_size != 2'b11));

    p_pad_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_size == 2'b10) |-> (mem_wdata[31:16] == 16'h0));

    p_byte_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_size == 2'b00) |-> (mem_wdata[31:8] == 24'h0));

    p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_stat[1]) |-> $past(ovf_evt));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr)));
endmodule

bind srx_dma_chan srx_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dma_en    (dma_en),
    .mem_wr    (mem_wr),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .ovf_flag  (ovf_flag),
    .desc_fire (desc_fire),
    .ovf_evt   (ovf_evt),
    .irq_stat  (irq_stat)
);

// File: tb/srx_dma_chan_bench.sv
module srx_dma_chan_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          dma_en, desc_valid, desc_done_ie, desc_err_ie;
    logic [AW-1:0] desc_addr, desc_stat_addr;
    logic [15:0]   desc_count;
    logic [1:0]    desc_size;
    logic          busy, ser_valid, pio_rd, word_irq, mem_wr, mem_ready, irq, ovf_flag;
    logic [15:0]   ser_data, pio_data;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size, irq_clr, irq_stat;
    logic [31:0]   mem_wdata;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] lg_addr [64];
    logic [31:0] lg_data [64];
    logic [1:0]  lg_size [64];
    int          lg_n = 0;

    always #5 clk = ~clk;

    srx_dma_chan u_srx_dma_chan (
        .clk(clk), .rst(rst), .dma_en(dma_en), .desc_valid(desc_valid),
        .desc_addr(desc_addr), .desc_stat_addr(desc_stat_addr),
        .desc_count(desc_count), .desc_size(desc_size),
        .desc_done_ie(desc_done_ie), .desc_err_ie(desc_err_ie), .busy(busy),
        .ser_valid(ser_valid), .ser_data(ser_data), .pio_rd(pio_rd),
        .pio_data(pio_data), .word_irq(word_irq), .mem_wr(mem_wr),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .irq_clr(irq_clr), .irq_stat(irq_stat),
        .irq(irq), .ovf_flag(ovf_flag)
    );

    // memory-side log of granted writes
    always @(negedge clk) begin
        if (!rst && mem_wr && mem_ready) begin
            lg_addr[lg_n % 64] = mem_addr;
            lg_data[lg_n % 64] = mem_wdata;
            lg_size[lg_n % 64] = mem_size;
            lg_n = lg_n + 1;
        end
    end

    typedef struct packed {
        logic [1:0]  sz;
        logic [15:0] d;
        logic [1:0]  msz;
        logic [2:0]  step;
    } vec_t;

    localparam vec_t [0:3] VECS = '{
        '{sz: 2'b00, d: 16'hA5C3, msz: 2'b00, step: 3'd1},
        '{sz: 2'b01, d: 16'h8001, msz: 2'b01, step: 3'd2},
        '{sz: 2'b10, d: 16'hF00D, msz: 2'b10, step: 3'd4},
        '{sz: 2'b11, d: 16'h7E42, msz: 2'b01, step: 3'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fit(input logic [1:0] sz, input logic [15:0] d);
        return (sz == 2'b00) ? {24'h0, d[7:0]} : {16'h0, d};
    endfunction

    task automatic send_desc(input logic [31:0] a, input logic [31:0] sa,
                             input logic [15:0] cnt, input logic [1:0] sz,
                             input logic die, input logic eie);
        @(negedge clk);
        desc_addr = a; desc_stat_addr = sa; desc_count = cnt;
        desc_size = sz; desc_done_ie = die; desc_err_ie = eie;
        desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
        chk("R2 busy after descriptor", {31'h0, busy}, 32'h1);
    endtask

    task automatic push_word(input logic [15:0] d);
        @(negedge clk);
        ser_valid = 1'b1; ser_data = d;
        @(negedge clk);
        ser_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 500; g++) begin
            @(negedge clk);
            if (!busy) break;
        end
        #1;
    endtask

    task automatic clear_irq(input logic [1:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = 2'b00;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int base;
        rst = 1'b1; dma_en = 1'b1; desc_valid = 1'b0; desc_addr = '0;
        desc_stat_addr = '0; desc_count = '0; desc_size = '0;
        desc_done_ie = 1'b0; desc_err_ie = 1'b0; ser_valid = 1'b0;
        ser_data = '0; pio_rd = 1'b0; mem_ready = 1'b1; irq_clr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 busy", {31'h0, busy}, 32'h0);
        chk("R11 mem_wr", {31'h0, mem_wr}, 32'h0);
        chk("R11 irq", {31'h0, irq}, 32'h0);
        chk("R11 irq_stat", {30'h0, irq_stat}, 32'h0);
        chk("R11 ovf_flag", {31'h0, ovf_flag}, 32'h0);
        chk("R11 word_irq", {31'h0, word_irq}, 32'h0);

        // table walk over transfer sizes: R4 R5 R6 R7 R9
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a0;
            a0 = 32'h1000 + 32'(i * 16);
            base = lg_n;
            send_desc(a0, 32'h2000, 16'd2, VECS[i].sz, 1'b1, 1'b0);
            push_word(VECS[i].d);
            push_word(~VECS[i].d);
            wait_idle();
            chk("R6 write count", 32'(lg_n - base), 32'd3);
            chk("R5 first addr", lg_addr[base % 64], a0);
            chk("R4 first data", lg_data[base % 64], fit(VECS[i].sz, VECS[i].d));
            chk("R4 size code", {30'h0, lg_size[base % 64]}, {30'h0, VECS[i].msz});
            chk("R5 second addr", lg_addr[(base + 1) % 64], a0 + 32'(VECS[i].step));
            chk("R4 second data", lg_data[(base + 1) % 64], fit(VECS[i].sz, ~VECS[i].d));
            chk("R6 record addr", lg_addr[(base + 2) % 64], 32'h2000);
            chk("R6 record clean", lg_data[(base + 2) % 64], 32'h0);
            chk("R6 record size", {30'h0, lg_size[(base + 2) % 64]}, 32'h2);
            chk("R7 done bit", {30'h0, irq_stat}, 32'h1);
            chk("R9 irq on", {31'h0, irq}, 32'h1);
            clear_irq(2'b01);
            chk("R9 cleared", {30'h0, irq_stat}, 32'h0);
        end

        // overflow under a stalled memory: R3 R8 R10 R6
        mem_ready = 1'b0;
        base = lg_n;
        send_desc(32'h3000, 32'h3800, 16'd4, 2'b01, 1'b1, 1'b1);
        for (int k = 0; k < 4; k++) push_word(16'h0010 + 16'(k));
        chk("R8 no error yet", {30'h0, irq_stat}, 32'h0);
        chk("R3 no overflow yet", {31'h0, ovf_flag}, 32'h0);
        chk("R10 request held", {31'h0, mem_wr}, 32'h1);
        chk("R10 address held", mem_addr, 32'h3000);
        chk("R10 nothing granted", 32'(lg_n - base), 32'd0);
        push_word(16'h0099);
        chk("R3 overflow flagged", {31'h0, ovf_flag}, 32'h1);
        chk("R8 error bit", {30'h0, irq_stat}, 32'h2);
        mem_ready = 1'b1;
        wait_idle();
        chk("R3 dropped word not written", 32'(lg_n - base), 32'd5);
        for (int k = 0; k < 4; k++)
            chk("R5 order", lg_data[(base + k) % 64], 32'h0010 + 32'(k));
        chk("R6 record overflow", lg_data[(base + 4) % 64], 32'h1);
        chk("R3 sticky past block", {31'h0, ovf_flag}, 32'h1);
        chk("R7 R8 both bits", {30'h0, irq_stat}, 32'h3);
        clear_irq(2'b10);
        chk("R9 clear only bit1", {30'h0, irq_stat}, 32'h1);
        chk("R9 irq still on", {31'h0, irq}, 32'h1);
        clear_irq(2'b01);
        chk("R9 irq off", {31'h0, irq}, 32'h0);

        // next block clears the overflow record; reserved size, no done irq
        base = lg_n;
        send_desc(32'h4000, 32'h4800, 16'd1, 2'b11, 1'b0, 1'b0);
        chk("R3 cleared on new descriptor", {31'h0, ovf_flag}, 32'h0);
        push_word(16'hBEEF);
        wait_idle();
        chk("R4 reserved as 16-bit data", lg_data[base % 64], 32'h0000BEEF);
        chk("R4 reserved size code", {30'h0, lg_size[base % 64]}, 32'h1);
        chk("R6 record clean again", lg_data[(base + 1) % 64], 32'h0);
        chk("R7 done bit off when disabled", {30'h0, irq_stat}, 32'h0);

        // word-interrupt mode: R1
        @(negedge clk);
        dma_en = 1'b0;
        base = lg_n;
        push_word(16'h1234);
        chk("R1 word interrupt", {31'h0, word_irq}, 32'h1);
        chk("R1 head visible", {16'h0, pio_data}, 32'h1234);
        @(negedge clk);
        chk("R1 single pulse", {31'h0, word_irq}, 32'h0);
        pio_rd = 1'b1;
        @(negedge clk);
        pio_rd = 1'b0;
        push_word(16'h5678);
        chk("R1 head after pop", {16'h0, pio_data}, 32'h5678);
        repeat (3) @(negedge clk);
        #1;
        chk("R1 no memory write", 32'(lg_n - base), 32'd0);

        summary();
        $finish;
    end
endmodule